// File: doc/BRIEF.md
# SMBus Clock-Stall and Bus-Idle Monitor

This block watches the two wires of an SMBus and reports two conditions. The first is a clock stall: some device has held SCL low for too long. The second is an idle bus: both wires have stayed high long enough that a new master may start. The serial engine next to it acts on the one-cycle stall pulse, for example by restarting itself, and uses the idle flag before it starts a transfer. Both line inputs must already be synchronized to `clk`.

The stall detector is an up-counter that advances on every `clk` cycle while SCL is low. Whenever SCL is high, or the detector is disabled, it is reloaded from `reload_val`. The pulse fires when the counter passes its all-ones value. Software picks `reload_val` so that the interval matches the 25 ms limit for its clock frequency: the interval is 2^CNT_W − reload_val cycles. The idle detector counts ticks from a slower clock source while both lines are high. It declares the bus free once it has seen more than `FREE_TICKS` such ticks.

Top module: `smbus_line_monitor`

## Requirements
- R1: During and just after reset, `stall_pulse` and `bus_free` are 0.
- R2: While `stall_en` is 1 and SCL is high, the low-time counter is held at `reload_val`. Each low period therefore starts a full interval again, and SCL that toggles with low periods shorter than the interval never produces a pulse.
- R3: The counter advances only on cycles where SCL is sampled low. With `stall_en` at 1, `stall_pulse` is 1 in the cycle after the (2^CNT_W − `reload_val`)th consecutive low sample.
- R4: `stall_pulse` is high for one cycle. After it fires, the counter stays at `reload_val` and no further pulse occurs until SCL has been sampled high.
- R5: While `stall_en` is 0, `stall_pulse` stays 0 and the counter is held at `reload_val`.
- R6: With `free_en` at 1, `bus_free` becomes 1 in the cycle after the (`FREE_TICKS`+1)th `src_tick` sample during which SCL and SDA have both stayed high. The default `FREE_TICKS` is 10.
- R7: Any cycle with SCL or SDA sampled low clears `bus_free` from the next cycle on and restarts the tick count from zero.
- R8: While `free_en` is 0, `bus_free` stays 0 and the tick count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| src_tick | input | 1 | One-cycle tick from the clock source of the idle detector |
| stall_en | input | 1 | Enables the SCL-low stall detector |
| free_en | input | 1 | Enables the bus-idle detector |
| reload_val | input | CNT_W | Start value of the low-time counter |
| stall_pulse | output | 1 | One-cycle pulse when the SCL-low interval expires |
| bus_free | output | 1 | High while the bus is considered idle |

## Verification
Both outputs are registered, so each one responds at the first clock edge that samples the stimulus that decides it. A stall pulse is due exactly one cycle after the last counted low sample. The idle flag rises one cycle after the qualifying tick and falls one cycle after a low sample. The bench drives inputs on falling edges and advances a behavioural model at rising edges, using cycle counts taken from the requirements. It compares both outputs at every falling edge. Targeted checks sit at the tenth and eleventh idle tick, and they count pulses across fast toggling, across held-low periods and while the detector is disabled.

// File: rtl/smbus_line_monitor.sv
module smbus_line_monitor #(
  parameter int CNT_W      = 16,
  parameter int FREE_TICKS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             src_tick,
  input  logic             stall_en,
  input  logic             free_en,
  input  logic [CNT_W-1:0] reload_val,
  output logic             stall_pulse,
  output logic             bus_free
);
  localparam int FW = $clog2(FREE_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [FW-1:0]    FREE_LIM = FW'(FREE_TICKS);

  logic [CNT_W-1:0] low_cnt;
  logic             fired;
  logic [FW-1:0]    free_cnt;

  wire lines_high = scl_i & sda_i;
  wire counting   = stall_en & ~scl_i & ~fired;
  wire wrap       = counting & (low_cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt     <= '0;
      fired       <= 1'b0;
      stall_pulse <= 1'b0;
    end else begin
      stall_pulse <= wrap;
      if (!stall_en || scl_i) begin
        low_cnt <= reload_val;
        fired   <= 1'b0;
      end else if (wrap) begin
        low_cnt <= reload_val;
        fired   <= 1'b1;
      end else if (counting) begin
        low_cnt <= low_cnt + 1'b1;
      end else begin
        low_cnt <= reload_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !free_en || !lines_high) begin
      free_cnt <= '0;
      bus_free <= 1'b0;
    end else if (src_tick && !bus_free) begin
      if (free_cnt == FREE_LIM) bus_free <= 1'b1;
      else                      free_cnt <= free_cnt + 1'b1;
    end
  end

  assert_hold_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_en && scl_i) |=> (low_cnt == $past(reload_val)));
  assert_low_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall_pulse |-> $past(stall_en && !scl_i));
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall_pulse |=> !stall_pulse);
  assert_stall_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_en |=> !stall_pulse);
  assert_free_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_free) |-> $past(src_tick && lines_high && free_en));
  assert_free_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lines_high |=> !bus_free);
  assert_free_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !free_en |=> !bus_free);
endmodule

// File: tb/test_smbus_line_monitor.sv
`timescale 1ns/1ps
module test_smbus_line_monitor;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, tick = 1'b0, s_en = 1'b0, f_en = 1'b0;
  logic [15:0] reload = 16'hFFF0;
  logic stall_pulse, bus_free;
  int checks = 0, fails = 0, cycles = 0, pulses = 0;
  string tag = "R1";

  int m_low = 0, m_ticks = 0;
  bit m_fired = 0, m_pulse = 0, m_free = 0;

  always #2.5 clk = ~clk;

  smbus_line_monitor i_smbus_line_monitor (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .src_tick(tick),
    .stall_en(s_en), .free_en(f_en), .reload_val(reload),
    .stall_pulse(stall_pulse), .bus_free(bus_free));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_low = 0; m_fired = 0; m_pulse = 0; m_ticks = 0; m_free = 0;
    end else begin
      m_pulse = 0;
      if (!s_en || scl) begin
        m_low = 0; m_fired = 0;
      end else if (!m_fired) begin
        m_low++;
        if (m_low == 65536 - int'(reload)) begin
          m_pulse = 1; m_fired = 1; m_low = 0;
        end
      end
      if (!f_en || !scl || !sda) begin
        m_ticks = 0; m_free = 0;
      end else if (tick) begin
        m_ticks++;
        if (m_ticks > 10) m_free = 1;
      end
    end
  end

  task automatic check(input string t, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %0b expected %0b", t, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(tag, "stall_pulse", stall_pulse, m_pulse);
      check(tag, "bus_free", bus_free, m_free);
      if (stall_pulse) pulses++;
    end
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    step(3);
    check("R1", "stall_pulse in reset", stall_pulse, 1'b0);
    check("R1", "bus_free in reset", bus_free, 1'b0);
    rst_n = 1'b1;
    step(1);
    check("R1", "stall_pulse after reset", stall_pulse, 1'b0);
    check("R1", "bus_free after reset", bus_free, 1'b0);

    tag = "R6"; s_en = 1'b1; f_en = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      tick = 1'b1; step(1); tick = 1'b0;
      if (k == 10) check("R6", "bus_free after tick 10", bus_free, 1'b0);
      if (k == 11) check("R6", "bus_free after tick 11", bus_free, 1'b1);
      step(2);
    end

    tag = "R7"; sda = 1'b0; step(1); sda = 1'b1;
    check("R7", "bus_free after SDA low", bus_free, 1'b0);
    for (int k = 0; k < 5; k++) begin tick = 1'b1; step(1); tick = 1'b0; step(1); end
    check("R7", "count restarted", bus_free, 1'b0);

    tag = "R2"; pulses = 0;
    for (int r = 0; r < 8; r++) begin
      scl = 1'b0; tick = 1'b1; step(15); tick = 1'b0; scl = 1'b1; step(2);
    end
    check("R2", "no pulse with fast SCL", pulses != 0, 1'b0);
    check("R7", "bus_free during SCL activity", bus_free, 1'b0);

    tag = "R3"; pulses = 0; scl = 1'b0; step(16);
    check("R3", "pulse after 16 low cycles", stall_pulse, 1'b1);
    tag = "R4"; step(40);
    check("R4", "exactly one pulse while held low", pulses == 1, 1'b1);
    scl = 1'b1; step(1); scl = 1'b0; step(16);
    check("R4", "pulse again after SCL high", stall_pulse, 1'b1);
    step(1);
    check("R4", "pulse lasts one cycle", stall_pulse, 1'b0);

    tag = "R3"; scl = 1'b1; reload = 16'hFFFD; step(2); pulses = 0;
    scl = 1'b0; step(2); scl = 1'b1; step(1); scl = 1'b0; step(3);
    check("R3", "pulse with reload FFFD", stall_pulse, 1'b1);
    scl = 1'b1; step(2);
    check("R3", "single pulse with reload FFFD", pulses == 1, 1'b1);

    tag = "R5"; s_en = 1'b0; pulses = 0; scl = 1'b0; step(30);
    check("R5", "no pulse while disabled", pulses == 0, 1'b1);
    s_en = 1'b1; step(2);
    check("R5", "full interval after enable", stall_pulse, 1'b0);
    step(1);
    check("R5", "pulse after enable interval", stall_pulse, 1'b1);
    scl = 1'b1; step(1);

    tag = "R8"; f_en = 1'b0;
    for (int k = 0; k < 14; k++) begin tick = 1'b1; step(1); tick = 1'b0; step(1); end
    check("R8", "bus_free while disabled", bus_free, 1'b0);
    f_en = 1'b1;
    for (int k = 0; k < 10; k++) begin tick = 1'b1; step(1); tick = 1'b0; step(1); end
    check("R8", "count cleared while disabled", bus_free, 1'b0);
    tick = 1'b1; step(1); tick = 1'b0;
    check("R6", "free after 11 ticks from enable", bus_free, 1'b1);
    step(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule